// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block sequences the power switching of several gateable logic domains, one domain at a time. Software-style commands arrive on a write-masked command port. Each domain has a one-bit data field and a matching enable bit sixteen positions above it. A command that asks for a change of state is held pending. The sequencer takes the pending domains in fixed priority order, lowest index first, and runs the bus-interface handshake and the power switch for each in the correct order. Every wait is bounded by a timeout.

For a power-down the sequencer raises the domain's idle request. It waits for the acknowledge and then for the idle indication, and only then asserts power-off. A power-up runs in the opposite order: it releases power-off, waits for the status to show the domain on, and then drops the idle request and waits for the acknowledge and the idle indication to clear. Each power switch step holds for a programmable transition count. There is one count for power-down and one for power-up. Some domains have no idle-request bit, no power bit or no status bit; the sequencer skips or adapts the matching steps for those domains.

States: `ST_IDLE` (nothing running), `ST_HS_ACK` (wait for the acknowledge to match the request), `ST_HS_IDLE` (wait for the idle indication to match), `ST_PW_DELAY` (power output switched, transition count running), `ST_PW_STAT` (wait for the status to match) and `ST_FINISH` (one cycle with the done pulse).

Transitions:
- `ST_IDLE` to the first step of the selected domain. A power-down starts with the handshake; a power-up starts with the power switch. Missing steps are skipped.
- `ST_HS_ACK` to `ST_HS_IDLE` when the acknowledge matches.
- `ST_HS_IDLE` to `ST_PW_DELAY` when the sequence is a power-down and the domain has a power bit. Otherwise it goes to `ST_FINISH`.
- `ST_PW_DELAY` to `ST_PW_STAT` when the count elapses.
- `ST_PW_STAT` to `ST_HS_ACK` when the sequence is a power-up and the domain has a request bit. Otherwise it goes to `ST_FINISH`.
- Any wait state to `ST_FINISH` on timeout.
- `ST_FINISH` to `ST_IDLE`.

Top module: `pwrdom_seq`

## Requirements
- R1: On power-down, a domain with an idle-request bit gets power-off asserted only after its idle request is high and its acknowledge and idle inputs have both reached 1.
- R2: On power-up of a domain with power and status bits, the idle request is dropped only after power-off is released and the status input reads 0. The sequence then waits for the acknowledge and idle inputs to return to 0.
- R3: A status input of 1 means the domain is off and 0 means it is on. A domain without a status bit counts as on exactly when its idle input is 0.
- R4: On a command write, bit n+16 enables domain n and bit n carries the request (1 = power off, 0 = power on). Domains whose enable bit is 0 are unaffected.
- R5: A domain without an idle-request bit never raises its idle request and goes straight to the power step. A domain without a power bit never asserts power-off and runs only the handshake.
- R6: If an ack, idle or status wait is not met within TMO_CYC cycles in that state, the sequence ends, err_o for that domain goes high and no further step runs. A stuck first wait keeps busy high for TMO_CYC+1 cycles. A later enabled write to that domain clears its error.
- R7: Separate transition counts are kept for power-down (cnt_sel=0) and power-up (cnt_sel=1). Each extra unit of the count lengthens only that direction's power step by one cycle.
- R8: A command asking for the state the domain is already in is dropped: no busy, no done and no output change.
- R9: Only one sequence runs at a time. When several domains are pending, the lowest index is served first.
- R10: busy_o is high from the cycle after acceptance through the done cycle. done_o pulses for one cycle per completed or failed sequence.
- R11: After reset, all power-off, idle-request and error outputs are low, busy_o and done_o are low, and both transition counts equal DLY_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 32 | Bit n+16 enables domain n; bit n requests off (1) or on (0) |
| cnt_we | input | 1 | Transition count write strobe |
| cnt_sel | input | 1 | 0 selects the power-down count, 1 the power-up count |
| cnt_val | input | DW | Transition count value |
| ack_in | input | N_DOM | Bus-interface idle acknowledge per domain |
| idle_in | input | N_DOM | Bus-interface idle indication per domain |
| stat_in | input | N_DOM | Power status per domain (1 = off) |
| pwr_off_o | output | N_DOM | Power-off request per domain |
| idle_req_o | output | N_DOM | Idle request to each domain's bus interface |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| err_o | output | N_DOM | Sticky per-domain timeout flag |

## Verification
The ordering assertions assume that each domain's inputs are caused only by the block's own outputs. The acknowledge follows the idle request, the idle indication follows the acknowledge, and the status follows power-off, and each input holds while its cause holds. The bench drives the domain side from a model with fixed latencies that obeys these rules. Its only departure is an option that forces one acknowledge to stay low, which exercises the timeout path without ever producing an input the block did not request.

// File: rtl/pwrdom_pkg.sv
package pwrdom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HS_ACK,
        ST_HS_IDLE,
        ST_PW_DELAY,
        ST_PW_STAT,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/pwrdom_pick.sv
module pwrdom_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          vld
);
    // Lowest set index wins.
    always_comb begin
        idx = '0;
        vld = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pwrdom_tick.sv
module pwrdom_tick #(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt
);
    // Saturating cycle counter, cleared on every state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (!(&cnt))  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwrdom_seq.sv
module pwrdom_seq
    import pwrdom_pkg::*;
#(
    parameter int               N_DOM    = 4,
    parameter int               DW       = 8,
    parameter int               DLY_RST  = 24,
    parameter int               TMO_CYC  = 10000,
    parameter logic [N_DOM-1:0] HAS_PWR  = '1,
    parameter logic [N_DOM-1:0] HAS_REQ  = '1,
    parameter logic [N_DOM-1:0] HAS_STAT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_data,
    input  logic             cnt_we,
    input  logic             cnt_sel,
    input  logic [DW-1:0]    cnt_val,
    input  logic [N_DOM-1:0] ack_in,
    input  logic [N_DOM-1:0] idle_in,
    input  logic [N_DOM-1:0] stat_in,
    output logic [N_DOM-1:0] pwr_off_o,
    output logic [N_DOM-1:0] idle_req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [N_DOM-1:0] err_o
);
    localparam int IW    = (N_DOM > 1) ? $clog2(N_DOM) : 1;
    localparam int SPAN  = (TMO_CYC > (1 << DW)) ? TMO_CYC : (1 << DW);
    localparam int TW    = $clog2(SPAN) + 1;
    localparam int EN_OF = 16;

    seq_state_t       st_q, st_d;
    logic [IW-1:0]    act_q, sel, cur;
    logic             sel_vld, dir_q, cur_dir, fail_q;
    logic [N_DOM-1:0] pend_q, pdir_q, pwr_q, req_q, err_q, dom_on, blk;
    logic [DW-1:0]    dly_dn_q, dly_up_q;
    logic [TW-1:0]    tcnt;
    logic             ack_ok, idle_ok, stat_ok, dly_ok, tmo, tmo_hit;
    logic             unused_cmd;

    assign unused_cmd = ^cmd_data;

    pwrdom_pick #(.N(N_DOM), .IW(IW)) u_pick (
        .req (pend_q),
        .idx (sel),
        .vld (sel_vld)
    );

    pwrdom_tick #(.TW(TW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_q != st_d),
        .cnt   (tcnt)
    );

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        assign dom_on[g] = HAS_STAT[g] ? !stat_in[g] : !idle_in[g];
        assign blk[g]    = (st_q != ST_IDLE) ? (act_q == IW'(g))
                                             : (sel_vld && sel == IW'(g));
    end

    assign cur     = (st_q == ST_IDLE) ? sel : act_q;
    assign cur_dir = (st_q == ST_IDLE) ? pdir_q[sel] : dir_q;
    assign ack_ok  = (ack_in[cur] == cur_dir);
    assign idle_ok = (idle_in[cur] == cur_dir);
    assign stat_ok = !HAS_STAT[cur] || (stat_in[cur] == cur_dir);
    assign dly_ok  = tcnt >= TW'(cur_dir ? dly_dn_q : dly_up_q);
    assign tmo     = tcnt >= TW'(TMO_CYC - 1);
    assign tmo_hit = tmo && ((st_q == ST_HS_ACK  && !ack_ok)  ||
                             (st_q == ST_HS_IDLE && !idle_ok) ||
                             (st_q == ST_PW_STAT && !stat_ok));

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (sel_vld) begin
                    if (cur_dir)
                        st_d = HAS_REQ[sel] ? ST_HS_ACK :
                               (HAS_PWR[sel] ? ST_PW_DELAY : ST_FINISH);
                    else
                        st_d = HAS_PWR[sel] ? ST_PW_DELAY :
                               (HAS_REQ[sel] ? ST_HS_ACK : ST_FINISH);
                end
            end
            ST_HS_ACK: begin
                if (ack_ok)   st_d = ST_HS_IDLE;
                else if (tmo) st_d = ST_FINISH;
            end
            ST_HS_IDLE: begin
                if (idle_ok)  st_d = (cur_dir && HAS_PWR[cur]) ? ST_PW_DELAY : ST_FINISH;
                else if (tmo) st_d = ST_FINISH;
            end
            ST_PW_DELAY: begin
                if (dly_ok)   st_d = ST_PW_STAT;
            end
            ST_PW_STAT: begin
                if (stat_ok)  st_d = (!cur_dir && HAS_REQ[cur]) ? ST_HS_ACK : ST_FINISH;
                else if (tmo) st_d = ST_FINISH;
            end
            ST_FINISH:        st_d = ST_IDLE;
            default:          st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Per-domain registers and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= '0;
            dir_q    <= 1'b0;
            fail_q   <= 1'b0;
            pend_q   <= '0;
            pdir_q   <= '0;
            pwr_q    <= '0;
            req_q    <= '0;
            err_q    <= '0;
            dly_dn_q <= DW'(DLY_RST);
            dly_up_q <= DW'(DLY_RST);
        end else begin
            if (cnt_we) begin
                if (cnt_sel) dly_up_q <= cnt_val;
                else         dly_dn_q <= cnt_val;
            end
            if (st_q == ST_IDLE && sel_vld) begin
                act_q       <= sel;
                dir_q       <= pdir_q[sel];
                fail_q      <= 1'b0;
                pend_q[sel] <= 1'b0;
            end
            for (int i = 0; i < N_DOM; i++) begin
                if (cmd_we && cmd_data[i + EN_OF] && !blk[i]) begin
                    pend_q[i] <= (cmd_data[i] == dom_on[i]);
                    pdir_q[i] <= cmd_data[i];
                    err_q[i]  <= 1'b0;
                end
            end
            if (st_d == ST_HS_ACK && st_q != ST_HS_ACK)     req_q[cur] <= cur_dir;
            if (st_d == ST_PW_DELAY && st_q != ST_PW_DELAY) pwr_q[cur] <= cur_dir;
            if (tmo_hit)                                    fail_q     <= 1'b1;
            if (st_q == ST_FINISH && fail_q)                err_q[act_q] <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        pwr_off_o  = pwr_q;
        idle_req_o = req_q;
        err_o      = err_q;
        busy_o     = (st_q != ST_IDLE);
        done_o     = (st_q == ST_FINISH);
    end

    // Assertions
    for (genvar g = 0; g < N_DOM; g++) begin : g_chk
        if (HAS_REQ[g]) begin : g_req
            assert_off_after_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pwr_off_o[g]) |-> (idle_req_o[g] && idle_in[g] && ack_in[g]));
        end
        if (HAS_PWR[g]) begin : g_pwr
            assert_release_after_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(idle_req_o[g]) |-> !pwr_off_o[g]);
        end
    end

    assert_single_domain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0((pwr_off_o ^ $past(pwr_off_o)) | (idle_req_o ^ $past(idle_req_o))));

    assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HS_ACK || st_q == ST_HS_IDLE || st_q == ST_PW_STAT) |-> (tcnt < TW'(TMO_CYC)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

endmodule

// File: tb/pwrdom_seq_test.sv
module pwrdom_seq_test;
    localparam int               N   = 4;
    localparam int               DW  = 8;
    localparam int               TMO = 32;
    localparam logic [N-1:0]     HP  = 4'b1011;
    localparam logic [N-1:0]     HR  = 4'b1101;
    localparam logic [N-1:0]     HS  = 4'b1011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [31:0]   cmd_data = '0;
    logic          cnt_we = 1'b0;
    logic          cnt_sel = 1'b0;
    logic [DW-1:0] cnt_val = '0;
    logic [N-1:0]  ack_in = '0, idle_in = '0, stat_in = '0;
    logic [N-1:0]  pwr_off_o, idle_req_o, err_o;
    logic          busy_o, done_o;

    int checks = 0, failures = 0, cyc = 0, done_n = 0;
    int rise_t [N];
    logic [N-1:0] stuck = '0;
    bit seen_r1 = 0, seen_p2 = 0;

    always #5 clk = ~clk;

    pwrdom_seq #(.N_DOM(N), .DW(DW), .DLY_RST(24), .TMO_CYC(TMO),
                 .HAS_PWR(HP), .HAS_REQ(HR), .HAS_STAT(HS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .cnt_we(cnt_we), .cnt_sel(cnt_sel), .cnt_val(cnt_val),
        .ack_in(ack_in), .idle_in(idle_in), .stat_in(stat_in),
        .pwr_off_o(pwr_off_o), .idle_req_o(idle_req_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Domain model: ack follows request, idle follows ack, status follows power-off
    initial begin
        logic [N-1:0] a1 = '0, a2 = '0, s1 = '0, s2 = '0;
        forever begin
            @(posedge clk);
            #2;
            idle_in = ack_in;
            a2 = a1; a1 = idle_req_o;
            ack_in = a2 & ~stuck;
            s2 = s1; s1 = pwr_off_o;
            stat_in = s2 & HS;
        end
    end

    // Ordering monitor
    initial begin
        logic [N-1:0] pp = '0, pr = '0;
        for (int d = 0; d < N; d++) rise_t[d] = -1;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                for (int d = 0; d < N; d++) begin
                    if (pwr_off_o[d] && !pp[d] && HR[d])
                        chk(idle_req_o[d] && idle_in[d], "R1 off-after-idle", idle_in[d], 1);
                    if (!idle_req_o[d] && pr[d] && HP[d] && HS[d])
                        chk(!pwr_off_o[d] && !stat_in[d], "R2 release-after-on", stat_in[d], 0);
                    if (idle_req_o[d] && !pr[d] && rise_t[d] < 0) rise_t[d] = cyc;
                end
                if (done_o) done_n++;
                if (idle_req_o[1]) seen_r1 = 1;
                if (pwr_off_o[2]) seen_p2 = 1;
            end
            pp = pwr_off_o;
            pr = idle_req_o;
        end
    end

    task automatic run_cmd(input logic [31:0] d, output int dur);
        int quiet;
        @(negedge clk); cmd_we = 1'b1; cmd_data = d;
        @(negedge clk); cmd_we = 1'b0; cmd_data = '0;
        dur = 0; quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (busy_o) begin dur++; quiet = 0; end
            else quiet++;
        end
    endtask

    task automatic set_cnt(input logic sel, input int v);
        @(negedge clk); cnt_we = 1'b1; cnt_sel = sel; cnt_val = DW'(v);
        @(negedge clk); cnt_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int dur, dn0, du [6], dd [6];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(pwr_off_o == 0 && idle_req_o == 0 && err_o == 0, "R11 outputs", {pwr_off_o, idle_req_o}, 0);
        chk(!busy_o && !done_o, "R11 busy/done", {busy_o, done_o}, 0);

        // R1 dom0 power-down, R11 reset count 24: 1+24+1+1 cycles of power step plus handshake
        dn0 = done_n;
        run_cmd(32'h0001_0001, dur);
        chk(pwr_off_o == 4'b0001 && idle_req_o == 4'b0001, "R1 dom0 off", pwr_off_o, 1);
        chk(done_n == dn0 + 1, "R10 one done", done_n - dn0, 1);
        // R2 dom0 power-up
        run_cmd(32'h0001_0000, dur);
        chk(pwr_off_o == 0 && idle_req_o == 0, "R2 dom0 on", {pwr_off_o, idle_req_o}, 0);
        chk(ack_in[0] == 0 && idle_in[0] == 0, "R2 ack/idle cleared", {ack_in[0], idle_in[0]}, 0);

        // R8 already-on command dropped
        dn0 = done_n;
        run_cmd(32'h0001_0000, dur);
        chk(dur == 0 && done_n == dn0, "R8 ignore on", dur, 0);

        // R4 data without enables has no effect
        run_cmd(32'h0000_000F, dur);
        chk(dur == 0 && pwr_off_o == 0, "R4 no enable", dur, 0);
        // R4 only enabled bit 1 acts; R5 dom1 has no request bit
        run_cmd(32'h0002_0003, dur);
        chk(pwr_off_o == 4'b0010 && idle_req_o == 0, "R4 masked write", pwr_off_o, 2);

        // R7 delay sweep on dom1 (power-only domain)
        for (int d = 0; d < 6; d++) begin
            set_cnt(1'b1, d);
            run_cmd(32'h0002_0000, du[d]);
            set_cnt(1'b0, d);
            run_cmd(32'h0002_0002, dd[d]);
            chk(du[d] == du[0] + d, "R7 up count", du[d], du[0] + d);
            chk(dd[d] == dd[0] + d, "R7 down count", dd[d], dd[0] + d);
        end
        set_cnt(1'b1, 20);
        set_cnt(1'b0, 0);
        run_cmd(32'h0002_0000, dur);
        chk(dur == du[0] + 20, "R7 up independent", dur, du[0] + 20);
        run_cmd(32'h0002_0002, dur);
        chk(dur == dd[0], "R7 down independent", dur, dd[0]);
        set_cnt(1'b1, 2);
        run_cmd(32'h0002_0000, dur);
        chk(pwr_off_o[1] == 0, "R7 dom1 back on", pwr_off_o[1], 0);

        // R3/R5 dom2: no power bit, no status bit
        run_cmd(32'h0004_0004, dur);
        chk(idle_req_o[2] && !pwr_off_o[2], "R5 dom2 handshake only", idle_req_o[2], 1);
        run_cmd(32'h0004_0004, dur);
        chk(dur == 0, "R3 idle domain reads off", dur, 0);
        run_cmd(32'h0004_0000, dur);
        chk(!idle_req_o[2], "R3 dom2 on", idle_req_o[2], 0);
        run_cmd(32'h0004_0000, dur);
        chk(dur == 0, "R3 non-idle domain reads on", dur, 0);
        run_cmd(32'h0001_0001, dur);
        run_cmd(32'h0001_0001, dur);
        chk(dur == 0, "R3 status 1 reads off", dur, 0);
        run_cmd(32'h0001_0000, dur);
        chk(!seen_r1 && !seen_p2, "R5 skipped steps", {seen_r1, seen_p2}, 0);

        // R9 priority: dom0 and dom3 together
        for (int d = 0; d < N; d++) rise_t[d] = -1;
        dn0 = done_n;
        run_cmd(32'h0009_0009, dur);
        chk(rise_t[0] > 0 && rise_t[0] < rise_t[3], "R9 lower index first", rise_t[0], rise_t[3]);
        chk(pwr_off_o == 4'b1001, "R9 both off", pwr_off_o, 9);
        chk(done_n == dn0 + 2, "R10 two done", done_n - dn0, 2);
        run_cmd(32'h0009_0000, dur);
        chk(pwr_off_o == 0 && idle_req_o == 0, "R9 both on", pwr_off_o, 0);

        // R6 timeout on a stuck acknowledge
        stuck = 4'b0001;
        dn0 = done_n;
        run_cmd(32'h0001_0001, dur);
        chk(dur == TMO + 1, "R6 busy length", dur, TMO + 1);
        chk(err_o == 4'b0001, "R6 error flag", err_o, 1);
        chk(pwr_off_o[0] == 0, "R6 no switch", pwr_off_o[0], 0);
        chk(done_n == dn0 + 1, "R10 done on fail", done_n - dn0, 1);
        stuck = '0;
        repeat (5) @(negedge clk);
        run_cmd(32'h0001_0001, dur);
        chk(err_o == 0 && pwr_off_o[0], "R6 recovery", err_o, 0);
        run_cmd(32'h0001_0000, dur);
        chk(pwr_off_o == 0 && idle_req_o == 0 && !busy_o, "R10 final idle", pwr_off_o, 0);

        summary();
        $finish;
    end
endmodule